// File: doc/BRIEF.md
# Receive Sampling-Delay Eye Calibrator

This block runs once while a source-synchronous parallel link is being brought up, before any payload is allowed across it. Its job is to pick the delay-line setting at which the receiver samples a lane most reliably. During calibration the far end transmits a known PRBS7 stream (polynomial x^7 + x^6 + 1). The block drives a 6-bit control code to a delay line on the forwarded clock. It steps that code through every value and, at each one, checks whether the recovered bit stream is free of errors.

At each code the block first waits for the delay line to settle. It then loads its own pattern generator from the first seven bits it receives. After that it compares every later bit against the generator's prediction for a fixed dwell. A code passes only if that whole dwell is free of mismatches. The passing codes form one or more contiguous runs, and each run is the open part of the eye as seen at that delay. The block keeps the widest run; when two runs are equally wide, the lower one wins. It then programs the code halfway between that run's first and last passing settings, pulses done and raises lock. If no code passes, it pulses fail, parks the code at zero and goes back to idle.

Top module: `eye_cal_top`

## Requirements
- R1: While reset is high and in the first cycle after it, delay_code_o is 0 and done_o, fail_o and lock_o are all low.
- R2: A start_i pulse seen in idle begins a sweep in the next cycle. delay_code_o steps through 0, 1, ..., 63 in increasing order and changes by exactly +1 at each step.
- R3: Each code is held for 8 settle cycles, then 7 seeding cycles, then DWELL check cycles (DWELL defaults to 128), for a total of 143 cycles per code at the default.
- R4: A code passes only if every bit received during its check cycles equals the output of a PRBS7 generator (each new bit is the XOR of the bits 7 and 6 positions earlier) that was seeded from the 7 bits received just before. The phase of the incoming stream does not matter.
- R5: Among the contiguous runs of passing codes, the widest one is chosen.
- R6: When two or more runs share the greatest width, the run with the lowest codes is chosen.
- R7: On success delay_code_o becomes (first + last) >> 1 of the chosen run, done_o is high for exactly one cycle, and lock_o rises in that same cycle.
- R8: If no code passes, fail_o is high for exactly one cycle (never together with done_o), delay_code_o is 0, lock_o stays low, and the block returns to idle so that a later start works.
- R9: lock_o stays high until the next accepted start_i and goes low in the cycle after that start.
- R10: A start_i pulse that arrives while a sweep is running has no effect on the sweep's sequence or timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock; one received bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a calibration sweep (accepted only in idle) |
| rx_bit_i | input | 1 | Recovered bit from the lane under calibration |
| delay_code_o | output | 6 | Control code for the receive clock delay line |
| done_o | output | 1 | One-cycle pulse: calibration succeeded |
| fail_o | output | 1 | One-cycle pulse: no error-free code was found |
| lock_o | output | 1 | High from a successful calibration until the next start |

## Verification
The following rules are checked by assertions on every clock:
- done and fail are single-cycle pulses and are never high together.
- During a sweep the code only ever advances by one, and each sweep begins at zero.
- lock can only rise together with done; it holds until a start and clears after one.
- A failure always leaves the code at zero.

Some behaviour can only be shown by the bench's scenarios, run against a model of the delay line that corrupts bits outside a chosen set of passing codes:
- the exact 143-cycle hold per code;
- rejection of corrupted codes;
- the choice of the widest run and the low-side tie break;
- the exact midpoint value;
- the absence of any effect from a start pulse in the middle of a sweep.

// File: rtl/eye_cal_pkg.sv
package eye_cal_pkg;

    localparam int CODE_W     = 6;
    localparam int LEN_W      = CODE_W + 1;
    localparam int PRBS_W     = 7;
    localparam int SETTLE_CYC = 8;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef enum logic [1:0] {
        PH_SETTLE,
        PH_SEED,
        PH_CHECK
    } phase_e;

    typedef enum logic {
        ST_IDLE,
        ST_SWEEP
    } cal_state_e;

    // A run of passing codes: lowest code and number of codes in it.
    typedef struct packed {
        code_t left;
        len_t  len;
    } window_t;

    // Next PRBS7 bit (x^7 + x^6 + 1); bit 6 is the oldest bit held.
    function automatic logic prbs7_feedback(input logic [PRBS_W-1:0] s);
        return s[6] ^ s[5];
    endfunction

    // Centre of a run: (first + last) >> 1, computed one bit wider.
    function automatic code_t eye_center(input window_t w);
        len_t last_ext;
        len_t sum_ext;
        last_ext = len_t'({1'b0, w.left}) + w.len - len_t'(1);
        sum_ext  = len_t'({1'b0, w.left}) + last_ext;
        return code_t'(sum_ext >> 1);
    endfunction

endpackage

// File: rtl/eye_dwell_seq.sv
module eye_dwell_seq
    import eye_cal_pkg::*;
#(
    parameter int DWELL = 128
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  logic   run,
    output phase_e phase,
    output logic   code_end
);

    localparam int CNT_W = $clog2(DWELL + SETTLE_CYC + PRBS_W + 1);

    logic [CNT_W-1:0] cnt_q;
    phase_e           phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= PH_SETTLE;
            cnt_q   <= '0;
        end else if (run) begin
            case (phase_q)
                PH_SETTLE: begin
                    if (cnt_q == CNT_W'(SETTLE_CYC - 1)) begin
                        phase_q <= PH_SEED;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_SEED: begin
                    if (cnt_q == CNT_W'(PRBS_W - 1)) begin
                        phase_q <= PH_CHECK;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == CNT_W'(DWELL - 1)) begin
                        phase_q <= PH_SETTLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign phase    = phase_q;
    assign code_end = run && (phase_q == PH_CHECK) && (cnt_q == CNT_W'(DWELL - 1));

endmodule

// File: rtl/eye_prbs_chk.sv
module eye_prbs_chk
    import eye_cal_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  phase_e phase,
    input  logic   rx_bit,
    output logic   code_pass
);

    logic [PRBS_W-1:0] gen_q;
    logic              err_q;
    logic              predicted;
    logic              mismatch;

    assign predicted = prbs7_feedback(gen_q);
    assign mismatch  = run && (phase == PH_CHECK) && (predicted != rx_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q <= '0;
            err_q <= 1'b0;
        end else if (run) begin
            case (phase)
                PH_SETTLE: err_q <= 1'b0;
                PH_SEED:   gen_q <= {gen_q[PRBS_W-2:0], rx_bit};
                default: begin
                    gen_q <= {gen_q[PRBS_W-2:0], predicted};
                    err_q <= err_q | mismatch;
                end
            endcase
        end
    end

    // Valid in the last check cycle: includes that cycle's comparison.
    assign code_pass = !err_q && !mismatch;

endmodule

// File: rtl/eye_win_track.sv
module eye_win_track
    import eye_cal_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  logic    step,
    input  logic    pass,
    input  code_t   code,
    output window_t best_nxt
);

    window_t run_q;
    window_t best_q;
    window_t run_upd;

    always_comb begin
        run_upd  = run_q;
        best_nxt = best_q;
        if (step) begin
            if (pass) begin
                run_upd.left = (run_q.len == '0) ? code : run_q.left;
                run_upd.len  = run_q.len + 1'b1;
                if (run_upd.len > best_q.len) begin
                    best_nxt = run_upd;
                end
            end else begin
                run_upd.len = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q  <= '0;
            best_q <= '0;
        end else begin
            run_q  <= run_upd;
            best_q <= best_nxt;
        end
    end

endmodule

// File: rtl/eye_cal_top.sv
module eye_cal_top
    import eye_cal_pkg::*;
#(
    parameter int DWELL = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rx_bit_i,
    output logic [CODE_W-1:0] delay_code_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              lock_o
);

    cal_state_e state_q;
    code_t      code_q;
    logic       done_q;
    logic       fail_q;
    logic       lock_q;

    logic       sweep_active;
    logic       start_go;
    phase_e     phase;
    logic       code_end;
    logic       code_pass;
    window_t    best_nxt;
    logic       last_code;

    assign sweep_active = (state_q == ST_SWEEP);
    assign start_go     = start_i && (state_q == ST_IDLE);
    assign last_code    = &code_q;

    eye_dwell_seq #(.DWELL(DWELL)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .restart  (start_go),
        .run      (sweep_active),
        .phase    (phase),
        .code_end (code_end)
    );

    eye_prbs_chk u_chk (
        .clk       (clk),
        .rst       (rst),
        .run       (sweep_active),
        .phase     (phase),
        .rx_bit    (rx_bit_i),
        .code_pass (code_pass)
    );

    eye_win_track u_trk (
        .clk      (clk),
        .rst      (rst),
        .clear    (start_go),
        .step     (code_end),
        .pass     (code_pass),
        .code     (code_q),
        .best_nxt (best_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_go) begin
                        state_q <= ST_SWEEP;
                        code_q  <= '0;
                        lock_q  <= 1'b0;
                    end
                end
                default: begin
                    if (code_end) begin
                        if (!last_code) begin
                            code_q <= code_q + 1'b1;
                        end else begin
                            state_q <= ST_IDLE;
                            if (best_nxt.len == '0) begin
                                code_q <= '0;
                                fail_q <= 1'b1;
                            end else begin
                                code_q <= eye_center(best_nxt);
                                done_q <= 1'b1;
                                lock_q <= 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign delay_code_o = code_q;
    assign done_o       = done_q;
    assign fail_o       = fail_q;
    assign lock_o       = lock_q;

endmodule

// File: rtl/eye_cal_sva.sv
module eye_cal_sva
    import eye_cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [CODE_W-1:0] delay_code_o,
    input logic              done_o,
    input logic              fail_o,
    input logic              lock_o,
    input logic              sweep_active
);

    assert_sweep_from_zero_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sweep_active) |-> delay_code_o == '0);

    assert_sweep_step_R2: assert property (@(posedge clk) disable iff (rst)
        (sweep_active && $past(sweep_active) && !$stable(delay_code_o))
            |-> delay_code_o == CODE_W'($past(delay_code_o) + 1'b1));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_lock_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> done_o);

    assert_fail_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> !fail_o);

    assert_fail_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(fail_o && done_o));

    assert_fail_code_R8: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> (delay_code_o == '0 && !lock_o));

    assert_lock_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (lock_o && !start_i) |=> lock_o);

    assert_lock_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (start_i && !sweep_active) |=> !lock_o);

endmodule

bind eye_cal_top eye_cal_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .delay_code_o (delay_code_o),
    .done_o       (done_o),
    .fail_o       (fail_o),
    .lock_o       (lock_o),
    .sweep_active (sweep_active)
);

// File: tb/eye_cal_top_tb_top.sv
module eye_cal_top_tb_top;

    localparam int DWELL     = 128;
    localparam int HOLD      = 8 + 7 + DWELL;
    localparam int NCODES    = 64;
    localparam int WATCHDOG  = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       rx_bit_i = 1'b0;
    logic [5:0] delay_code_o;
    logic       done_o;
    logic       fail_o;
    logic       lock_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [63:0] pass_mask = '0;
    logic [6:0]  tx_hist = 7'h5A;

    always #10 clk = ~clk;

    eye_cal_top #(.DWELL(DWELL)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .rx_bit_i     (rx_bit_i),
        .delay_code_o (delay_code_o),
        .done_o       (done_o),
        .fail_o       (fail_o),
        .lock_o       (lock_o)
    );

    // Transmitter plus delay-line model: codes outside pass_mask corrupt bits.
    always @(negedge clk) begin
        logic nb;
        nb = tx_hist[6] ^ tx_hist[5];
        tx_hist <= {tx_hist[5:0], nb};
        if (pass_mask[delay_code_o])
            rx_bit_i <= nb;
        else
            rx_bit_i <= nb ^ (($urandom % 4) == 0);
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R2 watchdog: actual hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] span(input int lo, input int hi);
        logic [63:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    // Expected result: widest run, lower run on ties, midpoint of its ends.
    function automatic void expect_cal(input logic [63:0] m, output bit ok, output int mid);
        int best_l = 0;
        int best_n = 0;
        int run_l = 0;
        int run_n = 0;
        for (int i = 0; i < 64; i++) begin
            if (m[i]) begin
                if (run_n == 0) run_l = i;
                run_n++;
                if (run_n > best_n) begin
                    best_n = run_n;
                    best_l = run_l;
                end
            end else begin
                run_n = 0;
            end
        end
        ok  = (best_n > 0);
        mid = ok ? (best_l + best_l + best_n - 1) / 2 : 0;
    endfunction

    task automatic run_cal(input logic [63:0] m, input string req, input bit poke_start);
        bit ok;
        int mid;
        int prev;
        int held;
        int samples;
        int seen;
        bit step_bad;
        expect_cal(m, ok, mid);
        pass_mask = m;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(lock_o == 1'b0, "R9", "lock after start", lock_o, 0);
        check(delay_code_o == 6'd0, "R2", "first sweep code", delay_code_o, 0);
        prev = 0; held = 0; samples = 0; seen = 1; step_bad = 0;
        while (!(done_o || fail_o) && samples < 20000) begin
            if (int'(delay_code_o) == prev) begin
                held++;
            end else begin
                if (held != HOLD) begin
                    check(0, "R3", "hold cycles per code", held, HOLD);
                    step_bad = 1;
                end
                if (int'(delay_code_o) != prev + 1) begin
                    check(0, "R2", "code step", delay_code_o, prev + 1);
                    step_bad = 1;
                end
                prev = delay_code_o;
                held = 1;
                seen++;
            end
            samples++;
            if (poke_start && samples == 3000) start_i = 1'b1;
            if (poke_start && samples == 3001) start_i = 1'b0;
            @(negedge clk);
        end
        check(!step_bad, "R3", "sweep timing clean", step_bad, 0);
        check(held == HOLD && prev == 63, "R3", "last code hold", held, HOLD);
        check(seen == NCODES, "R2", "codes visited", seen, NCODES);
        if (poke_start)
            check(samples == NCODES * HOLD, "R10", "sweep length with mid-sweep start",
                  samples, NCODES * HOLD);
        if (ok) begin
            check(done_o && !fail_o, $sformatf("%s R7", req), "done pulse", done_o, 1);
            check(int'(delay_code_o) == mid, $sformatf("%s R7", req), "centre code",
                  delay_code_o, mid);
            check(lock_o == 1'b1, "R7", "lock with done", lock_o, 1);
        end else begin
            check(fail_o && !done_o, "R8", "fail pulse", fail_o, 1);
            check(delay_code_o == 6'd0, "R8", "code after fail", delay_code_o, 0);
            check(lock_o == 1'b0, "R8", "lock after fail", lock_o, 0);
        end
        @(negedge clk);
        check(!done_o && !fail_o, "R7", "pulse width one cycle", done_o | fail_o, 0);
        repeat (5) @(negedge clk);
        check(lock_o == ok, "R9", "lock holds", lock_o, ok);
        check(int'(delay_code_o) == mid, "R9", "code holds in idle", delay_code_o, mid);
    endtask

    initial begin
        logic [63:0] m;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(delay_code_o == 6'd0 && !done_o && !fail_o && !lock_o, "R1",
              "outputs in reset", {delay_code_o, done_o, fail_o, lock_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(delay_code_o == 6'd0 && !done_o && !fail_o && !lock_o, "R1",
              "outputs after reset", {delay_code_o, done_o, fail_o, lock_o}, 0);

        run_cal(span(20, 35), "R4", 1'b0);
        run_cal(span(5, 10) | span(30, 45), "R5", 1'b0);
        run_cal(span(4, 9) | span(40, 45), "R6", 1'b0);
        run_cal(64'd0, "R8", 1'b0);
        run_cal(span(0, 63), "R5", 1'b0);
        run_cal(span(50, 63), "R10", 1'b1);
        run_cal(span(0, 0), "R7", 1'b0);
        for (int k = 0; k < 3; k++) begin
            m = '0;
            for (int r = 0; r < 3; r++) begin
                int lo;
                int hi;
                lo = $urandom % 64;
                hi = lo + int'($urandom % 12);
                if (hi > 63) hi = 63;
                m = m | span(lo, hi);
            end
            run_cal(m, "R5", 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule